// File: doc/BRIEF.md
# Loop Index Counter Unit

This unit keeps the running loop index of one thread's control-flow sequencer. A loop-start strobe loads a new loop context from a 96-bit packed constant: a trip count, an initial index and a signed step. Each iterate strobe, which the sequencer issues at the end of a loop body, either advances the index by the step or, on the last trip, ends the loop and raises a one-cycle done flag. The current index is offered to the datapath for relative addressing.

Loops may nest. When a loop is already running and a new one starts, the running context (index, remaining trips, step) is saved on a small LIFO stack. Ending or breaking out of the inner loop restores the outer context in the same cycle. Misuse, such as nesting too deep or iterating with no loop running, sets a sticky error flag and leaves all other state alone.

The controller has two states. ST_IDLE means no loop is running and the index reads zero. ST_RUN means a loop is running. The transitions are T_START (ST_IDLE to ST_RUN on a start with a nonzero trip count), T_NEST (ST_RUN to ST_RUN, saving the outer context and loading the new one), T_STEP (ST_RUN to ST_RUN, advancing the index), T_FINISH (the last iterate: restore the outer context, or go to ST_IDLE when none is saved), T_BREAK (the same exit without done), T_SKIP (zero trip count: done only) and T_FAULT (error flag only).

Top module: `loop_index_unit`

## Requirements
- R1: During and right after reset, index_o is 0, done_o is 0, err_o is 0 and no loop is running.
- R2: The constant word holds the trip count (unsigned) in bits [31:0], the initial index in bits [44:32] (the low 13 bits of the second word) and the step, as 13-bit two's complement, in bits [76:64]. The upper bits of the second and third words are ignored. A start with a nonzero trip count shows the initial index on index_o after the next clock edge.
- R3: An iterate that is not the last trip adds the step to the index modulo 2^13, so negative steps and wrap-around both work.
- R4: For a trip count N, the Nth iterate ends the loop and pulses done_o high for exactly one cycle.
- R5: A start with a zero trip count pulses done_o and leaves the index, the running loop and the stack unchanged.
- R6: A start while a loop is running saves the outer context. When the inner loop finishes, the outer loop's index, remaining trips and step come back in the same cycle.
- R7: A break leaves the innermost loop in one cycle without pulsing done_o. It restores the outer index, or returns the index to 0 and goes idle when no outer loop is saved.
- R8: Up to 4 outer contexts can be saved, which allows 5 running loops. A start that would need a fifth save sets err_o and changes nothing else.
- R9: An iterate or break while no loop is running sets err_o and changes nothing else.
- R10: err_o stays high until reset once it is set.
- R11: When strobes arrive in the same cycle, break takes priority over iterate, and iterate takes priority over start. The losing strobes are ignored.
- R12: In a cycle with no strobe, index_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_start_i | input | 1 | Start a loop from loop_const_i |
| loop_iter_i | input | 1 | End of one loop body |
| loop_break_i | input | 1 | Leave the innermost loop |
| loop_const_i | input | 96 | Packed trip count, initial index and step |
| index_o | output | 13 | Current loop index |
| done_o | output | 1 | One-cycle pulse when a loop's trips are used up |
| err_o | output | 1 | Sticky nesting or sequencing error |

## Verification
A corrupted saved context shows up on index_o in the cycle right after the inner loop ends or breaks, because the restored value is driven straight from the stack. A wrong remaining-trip count shows up as done_o pulsing one iterate early or late, so the bench checks done_o on every cycle of every loop. A wrong stack pointer shows up either as err_o rising one nesting level too early, or as a break restoring the wrong outer index. The bench walks five levels deep and unwinds them one by one to expose both.

// File: rtl/lidx_pkg.sv
package lidx_pkg;
    parameter int IDX_W  = 13;
    parameter int WORD_W = 32;
    localparam int CONST_W = 3 * WORD_W;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] left;
        logic [IDX_W-1:0]  step;
    } lctx_t;

    localparam int CTX_W = $bits(lctx_t);

    typedef enum logic {ST_IDLE, ST_RUN} lst_t;
    typedef enum logic [1:0] {OP_HOLD, OP_LOAD, OP_STEP, OP_EXIT} lop_t;
endpackage

// File: rtl/lidx_stack.sv
module lidx_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 58
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0] ptr;
    logic [W-1:0]  mem [DEPTH];

    assign full_o  = (ptr == PW'(DEPTH));
    assign empty_o = (ptr == '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (push_i && !full_o && ptr == PW'(g))
                mem[g] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (push_i && !full_o)
            ptr <= ptr + 1'b1;
        else if (pop_i && !empty_o)
            ptr <= ptr - 1'b1;
    end

    always_comb begin
        data_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (ptr == PW'(i + 1)) data_o = mem[i];
    end

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R8
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R7
    AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R11
endmodule

// File: rtl/lidx_datapath.sv
module lidx_datapath
    import lidx_pkg::*;
(
    input  logic [CONST_W-1:0] const_i,
    input  lctx_t              cur_i,
    output lctx_t              load_o,
    output logic               trip_zero_o,
    output logic [IDX_W-1:0]   next_idx_o,
    output logic [WORD_W-1:0]  left_dec_o,
    output logic               last_o
);
    logic [WORD_W-1:0] w_trip, w_init, w_step;
    logic              const_unused;

    assign w_trip = const_i[WORD_W-1:0];
    assign w_init = const_i[2*WORD_W-1:WORD_W];
    assign w_step = const_i[3*WORD_W-1:2*WORD_W];
    assign const_unused = ^{w_init[WORD_W-1:IDX_W], w_step[WORD_W-1:IDX_W]};

    always_comb begin
        load_o.idx  = w_init[IDX_W-1:0];
        load_o.left = w_trip;
        load_o.step = w_step[IDX_W-1:0];
    end

    assign trip_zero_o = (w_trip == '0);
    assign next_idx_o  = cur_i.idx + cur_i.step;
    assign left_dec_o  = cur_i.left - 1'b1;
    assign last_o      = (cur_i.left == WORD_W'(1));
endmodule

// File: rtl/lidx_fsm.sv
module lidx_fsm
    import lidx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic iter_i,
    input  logic brk_i,
    input  logic trip_zero_i,
    input  logic last_i,
    input  logic stk_full_i,
    input  logic stk_empty_i,
    output lop_t op_o,
    output logic push_o,
    output logic pop_o,
    output logic done_set_o,
    output logic err_set_o,
    output logic run_o
);
    lst_t st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt     = st;
        op_o       = OP_HOLD;
        done_set_o = 1'b0;
        err_set_o  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (brk_i || iter_i) begin
                    err_set_o = 1'b1;                 // T_FAULT
                end else if (start_i) begin
                    if (trip_zero_i) begin
                        done_set_o = 1'b1;            // T_SKIP
                    end else begin
                        op_o   = OP_LOAD;             // T_START
                        st_nxt = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (brk_i) begin
                    op_o   = OP_EXIT;                 // T_BREAK
                    st_nxt = stk_empty_i ? ST_IDLE : ST_RUN;
                end else if (iter_i) begin
                    if (last_i) begin
                        op_o       = OP_EXIT;         // T_FINISH
                        done_set_o = 1'b1;
                        st_nxt     = stk_empty_i ? ST_IDLE : ST_RUN;
                    end else begin
                        op_o = OP_STEP;               // T_STEP
                    end
                end else if (start_i) begin
                    if (trip_zero_i)     done_set_o = 1'b1;  // T_SKIP
                    else if (stk_full_i) err_set_o  = 1'b1;  // T_FAULT
                    else                 op_o       = OP_LOAD; // T_NEST
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o  = (st == ST_RUN);
        push_o = (op_o == OP_LOAD) && (st == ST_RUN);
        pop_o  = (op_o == OP_EXIT) && !stk_empty_i;
    end
endmodule

// File: rtl/loop_index_unit.sv
module loop_index_unit
    import lidx_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loop_start_i,
    input  logic               loop_iter_i,
    input  logic               loop_break_i,
    input  logic [CONST_W-1:0] loop_const_i,
    output logic [IDX_W-1:0]   index_o,
    output logic               done_o,
    output logic               err_o
);
    lctx_t             cur, load_ctx, saved_ctx;
    logic [CTX_W-1:0]  saved_bits;
    logic              trip_zero, last, stk_full, stk_empty;
    logic              push, pop, done_set, err_set, run;
    logic [IDX_W-1:0]  next_idx;
    logic [WORD_W-1:0] left_dec;
    lop_t              op;

    lidx_datapath u_dp (
        .const_i(loop_const_i), .cur_i(cur), .load_o(load_ctx),
        .trip_zero_o(trip_zero), .next_idx_o(next_idx),
        .left_dec_o(left_dec), .last_o(last)
    );

    lidx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(loop_start_i), .iter_i(loop_iter_i),
        .brk_i(loop_break_i), .trip_zero_i(trip_zero), .last_i(last),
        .stk_full_i(stk_full), .stk_empty_i(stk_empty), .op_o(op),
        .push_o(push), .pop_o(pop), .done_set_o(done_set),
        .err_set_o(err_set), .run_o(run)
    );

    lidx_stack #(.DEPTH(STACK_DEPTH), .W(CTX_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .data_i(cur), .data_o(saved_bits), .full_o(stk_full), .empty_o(stk_empty)
    );

    assign saved_ctx = lctx_t'(saved_bits);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            unique case (op)
                OP_HOLD: ;
                OP_LOAD: cur <= load_ctx;
                OP_STEP: begin
                    cur.idx  <= next_idx;
                    cur.left <= left_dec;
                end
                OP_EXIT: cur <= stk_empty ? '0 : saved_ctx;
                default: ;
            endcase
            done_o <= done_set;
            err_o  <= err_o | err_set;
        end
    end

    assign index_o = cur.idx;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_start_i || loop_iter_i || loop_break_i) |=> $stable(index_o)); // R12
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (index_o == '0)); // R1
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(loop_start_i || loop_iter_i)); // R4
    AST_IDLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && (loop_iter_i || loop_break_i)) |=> (err_o && index_o == '0)); // R9
endmodule

// File: tb/loop_index_unit_bench.sv
module loop_index_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_s = 1'b0, it_s = 1'b0, br_s = 1'b0;
    logic [95:0] cw = '0;
    logic [12:0] index_o;
    logic        done_o, err_o;

    int n_run = 0, n_fail = 0;

    typedef struct {
        logic [12:0] idx;
        logic        dn;
        logic        er;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    loop_index_unit u_loop_index_unit (
        .clk(clk), .rst_n(rst_n), .loop_start_i(st_s), .loop_iter_i(it_s),
        .loop_break_i(br_s), .loop_const_i(cw), .index_o(index_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [95:0] mk(input logic [31:0] trip, input logic [31:0] init,
                                       input logic [31:0] step);
        return {step, init, trip};
    endfunction

    task automatic check(input string tag, input logic [12:0] ei, input logic ed, input logic ee);
        n_run++;
        if (index_o !== ei || done_o !== ed || err_o !== ee) begin
            n_fail++;
            $display("FAIL %s: idx=%0d done=%0b err=%0b, expected idx=%0d done=%0b err=%0b",
                     tag, index_o, done_o, err_o, ei, ed, ee);
        end
    endtask

    task automatic drv(input logic s, input logic i, input logic b, input logic [95:0] c,
                       input logic [12:0] ei, input logic ed, input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        st_s = s; it_s = i; br_s = b; cw = c;
        e.idx = ei; e.dn = ed; e.er = ee; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic quiet(input logic [12:0] ei, input logic ee, input string tag);
        drv(1'b0, 1'b0, 1'b0, '0, ei, 1'b0, ee, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        st_s = 0; it_s = 0; br_s = 0; cw = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", 13'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // monitor: compares one expected item per cycle after the clock edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, e.idx, e.dn, e.er);
        end
    end

    initial begin : watchdog
        #200000ns;
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        quiet(0, 0, "R1/R12 idle after reset");
        // basic loop: trip 3, init 100, step 5
        drv(1, 0, 0, mk(3, 100, 5), 100, 0, 0, "R2 load initial");
        drv(0, 1, 0, '0, 105, 0, 0, "R3 step");
        drv(0, 1, 0, '0, 110, 0, 0, "R3 step");
        drv(0, 1, 0, '0, 0, 1, 0, "R4 last trip done");
        quiet(0, 0, "R4 done single pulse");
        // wrap and nesting with negative step (upper bits set, must be ignored)
        drv(1, 0, 0, mk(2, 32'hABCD_1FFE, 3), 8190, 0, 0, "R2 upper bits ignored");
        drv(0, 1, 0, '0, 1, 0, 0, "R3 wrap modulo");
        drv(1, 0, 0, mk(2, 50, 32'hFFFF_FFFE), 50, 0, 0, "R6 nested load");
        drv(0, 1, 0, '0, 48, 0, 0, "R3 negative step");
        drv(0, 1, 0, '0, 1, 1, 0, "R6 outer restored at finish");
        drv(0, 1, 0, '0, 0, 1, 0, "R6 outer remaining trips restored");
        // zero trip count
        drv(1, 0, 0, mk(0, 77, 1), 0, 1, 0, "R5 zero trip idle");
        drv(1, 0, 0, mk(5, 10, 1), 10, 0, 0, "R2 load");
        drv(1, 0, 0, mk(0, 99, 1), 10, 1, 0, "R5 zero trip nested");
        drv(0, 1, 0, '0, 11, 0, 0, "R5 loop unchanged");
        drv(1, 0, 0, mk(4, 200, 1), 200, 0, 0, "R6 nested load");
        drv(0, 0, 1, '0, 11, 0, 0, "R7 break restores outer");
        drv(0, 1, 0, '0, 12, 0, 0, "R7 outer continues");
        drv(1, 1, 1, mk(3, 70, 1), 0, 0, 0, "R11 break wins, R7 go idle");
        drv(0, 1, 0, '0, 0, 0, 1, "R9 iterate while idle");
        quiet(0, 1, "R10 error sticky");
        quiet(0, 1, "R10 error sticky");
        @(posedge clk); #2;
        do_reset();
        // depth limit
        drv(1, 0, 0, mk(9, 1, 1), 1, 0, 0, "R8 level 1");
        drv(1, 0, 0, mk(9, 2, 1), 2, 0, 0, "R8 level 2");
        drv(1, 0, 0, mk(9, 3, 1), 3, 0, 0, "R8 level 3");
        drv(1, 0, 0, mk(9, 4, 1), 4, 0, 0, "R8 level 4");
        drv(1, 0, 0, mk(9, 5, 1), 5, 0, 0, "R8 level 5");
        drv(1, 0, 0, mk(9, 6, 1), 5, 0, 1, "R8 overflow rejected");
        drv(0, 1, 0, '0, 6, 0, 1, "R8 state unchanged");
        drv(0, 0, 1, '0, 4, 0, 1, "R7 unwind");
        drv(0, 0, 1, '0, 3, 0, 1, "R7 unwind");
        drv(0, 0, 1, '0, 2, 0, 1, "R7 unwind");
        drv(0, 0, 1, '0, 1, 0, 1, "R7 unwind");
        drv(0, 0, 1, '0, 0, 0, 1, "R7 last break idle");
        drv(0, 0, 1, '0, 0, 0, 1, "R9 break while idle");
        // iterate beats start
        drv(1, 0, 0, mk(2, 20, 1), 20, 0, 1, "R2 load");
        drv(1, 1, 0, mk(3, 70, 1), 21, 0, 1, "R11 iterate wins");
        drv(0, 1, 0, '0, 0, 1, 1, "R11 start ignored, R4 done");
        quiet(0, 1, "R12 quiet");
        @(posedge clk); #2;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule